// File: doc/BRIEF.md
# Windowed Watchdog Timer with Two-Byte Service Key

The block is a watchdog counter that asks for a system reset when software stops servicing it. A 2-bit period select either switches the watchdog off or picks one of three power-of-two periods. A source select decides what the counter counts. With the slow source it counts single-cycle tick pulses from a low-power timebase, and with the fast source it counts every bus clock. Software services the watchdog by writing the byte 0x55 and then the byte 0xAA to a service port, and this restarts the period.

An optional window mode applies only with the bus clock as the source. In this mode, any write to the service port during the first three quarters of the period is taken as a fault. The source select and window enable are captured from the first configuration write after reset and are frozen after that. The period select stays writable. Every configuration write restarts the period.

When the period ends without a completed service, or when a window fault occurs, the block raises a one-cycle reset request. It then restarts its count and clears the service sequence. The configuration is kept.

Top module: `wdog_top`

## Requirements
- R1: With period select 00 the watchdog is off. The counter stays at zero, service writes have no effect and `rst_req` never rises.
- R2: With the low-power source (`cfg_bus_clk`=0), period selects 01, 10 and 11 raise `rst_req` on the 32nd, 256th and 1024th `tick_en` pulse after the period starts. Bus cycles without a tick do not advance the count.
- R3: With the bus-clock source (`cfg_bus_clk`=1), period selects 01, 10 and 11 raise `rst_req` 8192, 65536 and 262144 cycles after the clock edge that starts the period.
- R4: A write of 0x55 followed by a write of 0xAA restarts the period. The restart happens at the edge that takes the 0xAA write, and no reset request is made. A configuration write also restarts the period.
- R5: In window mode, a service-port write of any value at an edge where fewer than 3/4 of the period's cycles have elapsed (6144 for select 01) raises `rst_req` in the next cycle.
- R6: `cfg_bus_clk` and `cfg_window` both reset to 0 and are taken only from the first `cfg_wr` after reset. Later writes update only `cfg_tsel`.
- R7: In window mode, writes at or after the 3/4 point are accepted, and a 0x55/0xAA pair made there services the watchdog.
- R8: A byte other than 0xAA written after 0x55 abandons the sequence. It does not service the watchdog and, in normal mode, makes no reset request.
- R9: `rst_req` is high for exactly one cycle. In that cycle the count has already been restarted from zero.
- R10: With the low-power source the window enable has no effect, so early service writes make no reset request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Single-cycle low-power timebase pulse |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_bus_clk | input | 1 | Source select: 0 low-power tick, 1 bus clock (first write only) |
| cfg_window | input | 1 | Window mode enable (first write only) |
| cfg_tsel | input | 2 | Period select: 00 off, 01/10/11 short/medium/long |
| svc_wr | input | 1 | Service port write strobe |
| svc_data | input | 8 | Service port write byte |
| rst_req | output | 1 | One-cycle system reset request |

## Verification
The bench first drives a random mix of service bytes and ticks while the watchdog is off; any reset request in that phase is an error. Tick trains with random gaps then tell a tick-driven count apart from a cycle-driven one, and they show whether a later source-select write was ignored. In bus mode, directed service pairs, abandoned pairs and window-edge writes at exactly 6143 and 6144 elapsed cycles check for off-by-one faults in the window compare, in the restart point and in sequence handling. Each of these checks measures the exact cycle in which the reset request appears.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    typedef enum logic {
        SEQ_IDLE  = 1'b0,
        SEQ_ARMED = 1'b1
    } seq_t;

    typedef struct packed {
        logic       clk_bus;
        logic       win;
        logic [1:0] tsel;
    } wcfg_t;

    localparam logic [7:0] KEY_FIRST  = 8'h55;
    localparam logic [7:0] KEY_SECOND = 8'hAA;

    function automatic int unsigned pick_exp(
        input wcfg_t       c,
        input int unsigned lp1, input int unsigned lp2, input int unsigned lp3,
        input int unsigned bc1, input int unsigned bc2, input int unsigned bc3
    );
        int unsigned e;
        case (c.tsel)
            2'b01:   e = c.clk_bus ? bc1 : lp1;
            2'b10:   e = c.clk_bus ? bc2 : lp2;
            2'b11:   e = c.clk_bus ? bc3 : lp3;
            default: e = 2;
        endcase
        return e;
    endfunction

    function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/wdog_cfg.sv
module wdog_cfg
    import wdog_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr,
    input  logic       bus_clk,
    input  logic       window,
    input  logic [1:0] tsel,
    output wcfg_t      cfg_q,
    output logic       locked
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q  <= '0;
            locked <= 1'b0;
        end else if (wr) begin
            cfg_q.tsel <= tsel;
            if (!locked) begin
                cfg_q.clk_bus <= bus_clk;
                cfg_q.win     <= window;
                locked        <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter
    import wdog_pkg::*;
#(
    parameter int unsigned LP_EXP1 = 5,
    parameter int unsigned LP_EXP2 = 8,
    parameter int unsigned LP_EXP3 = 10,
    parameter int unsigned BC_EXP1 = 13,
    parameter int unsigned BC_EXP2 = 16,
    parameter int unsigned BC_EXP3 = 18,
    parameter int unsigned CNT_W   = 18
) (
    input  logic             clk,
    input  logic             rst,
    input  wcfg_t            cfg,
    input  logic             tick_en,
    input  logic             clr,
    output logic [CNT_W-1:0] cnt,
    output logic             enabled,
    output logic             ovf,
    output logic             win_open
);
    localparam int unsigned SPAN_W = CNT_W + 1;

    logic [SPAN_W-1:0] span;
    logic [SPAN_W-1:0] cnt_ext;
    logic              adv;

    always_comb begin
        span    = {{(SPAN_W-1){1'b0}}, 1'b1} << pick_exp(cfg, LP_EXP1, LP_EXP2, LP_EXP3,
                                                          BC_EXP1, BC_EXP2, BC_EXP3);
        cnt_ext = {1'b0, cnt};
        enabled = (cfg.tsel != 2'b00);
        adv     = enabled && (cfg.clk_bus || tick_en);
        ovf     = adv && (cnt_ext >= span - 1'b1);
        win_open = (cnt_ext >= span - (span >> 2));
    end

    always_ff @(posedge clk) begin
        if (rst || !enabled || clr)
            cnt <= '0;
        else if (adv)
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/wdog_seq.sv
module wdog_seq
    import wdog_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       enabled,
    input  logic       win_active,
    input  logic       win_open,
    input  logic       wr,
    input  logic [7:0] data,
    input  logic       clr,
    output logic       early,
    output logic       done
);
    seq_t state;

    always_comb begin
        early = wr && win_active && !win_open;
        done  = wr && !early && enabled && (state == SEQ_ARMED) && (data == KEY_SECOND);
    end

    always_ff @(posedge clk) begin
        if (rst || !enabled || clr)
            state <= SEQ_IDLE;
        else if (wr)
            state <= (state == SEQ_IDLE && data == KEY_FIRST) ? SEQ_ARMED : SEQ_IDLE;
    end
endmodule

// File: rtl/wdog_top.sv
module wdog_top
    import wdog_pkg::*;
#(
    parameter int unsigned LP_EXP1 = 5,
    parameter int unsigned LP_EXP2 = 8,
    parameter int unsigned LP_EXP3 = 10,
    parameter int unsigned BC_EXP1 = 13,
    parameter int unsigned BC_EXP2 = 16,
    parameter int unsigned BC_EXP3 = 18
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick_en,
    input  logic       cfg_wr,
    input  logic       cfg_bus_clk,
    input  logic       cfg_window,
    input  logic [1:0] cfg_tsel,
    input  logic       svc_wr,
    input  logic [7:0] svc_data,
    output logic       rst_req
);
    localparam int unsigned CNT_W = max3(max3(LP_EXP1, LP_EXP2, LP_EXP3),
                                         max3(BC_EXP1, BC_EXP2, BC_EXP3), 2);

    wcfg_t            cfg_q;
    logic             locked;
    logic [CNT_W-1:0] cnt;
    logic             enabled, ovf, win_open, win_active;
    logic             early, done, evt;

    wdog_cfg u_cfg (
        .clk(clk), .rst(rst), .wr(cfg_wr), .bus_clk(cfg_bus_clk),
        .window(cfg_window), .tsel(cfg_tsel), .cfg_q(cfg_q), .locked(locked)
    );

    wdog_counter #(
        .LP_EXP1(LP_EXP1), .LP_EXP2(LP_EXP2), .LP_EXP3(LP_EXP3),
        .BC_EXP1(BC_EXP1), .BC_EXP2(BC_EXP2), .BC_EXP3(BC_EXP3), .CNT_W(CNT_W)
    ) u_cnt (
        .clk(clk), .rst(rst), .cfg(cfg_q), .tick_en(tick_en),
        .clr(done || evt || cfg_wr), .cnt(cnt), .enabled(enabled),
        .ovf(ovf), .win_open(win_open)
    );

    assign win_active = cfg_q.win && cfg_q.clk_bus && enabled;

    wdog_seq u_seq (
        .clk(clk), .rst(rst), .enabled(enabled), .win_active(win_active),
        .win_open(win_open), .wr(svc_wr), .data(svc_data),
        .clr(evt || cfg_wr), .early(early), .done(done)
    );

    // A service completing on the final count wins over the overflow.
    assign evt = (ovf && !done) || early;

    always_ff @(posedge clk) begin
        if (rst) rst_req <= 1'b0;
        else     rst_req <= evt;
    end
endmodule

// File: rtl/wdog_checker.sv
module wdog_checker
    import wdog_pkg::*;
#(
    parameter int unsigned CNT_W = 18
) (
    input logic             clk,
    input logic             rst,
    input logic             tick_en,
    input logic             cfg_wr,
    input logic             svc_wr,
    input logic             rst_req,
    input wcfg_t            cfg_q,
    input logic             locked,
    input logic [CNT_W-1:0] cnt,
    input logic             win_open
);
    p_off_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.tsel == 2'b00 && !cfg_wr) |=> !rst_req);

    p_tick_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (!cfg_q.clk_bus && !tick_en && !svc_wr && !cfg_wr) |=> $stable(cnt));

    p_early_fault_r5: assert property (@(posedge clk) disable iff (rst)
        (svc_wr && cfg_q.win && cfg_q.clk_bus && cfg_q.tsel != 2'b00 && !win_open)
        |=> rst_req);

    p_write_once_r6: assert property (@(posedge clk) disable iff (rst)
        locked |=> ($stable(cfg_q.clk_bus) && $stable(cfg_q.win)));

    p_pulse_clear_r9: assert property (@(posedge clk) disable iff (rst)
        rst_req |-> (cnt == '0));

    p_tick_no_window_r10: assert property (@(posedge clk) disable iff (rst)
        (!cfg_q.clk_bus && !tick_en) |=> !rst_req);
endmodule

bind wdog_top wdog_checker #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst(rst), .tick_en(tick_en), .cfg_wr(cfg_wr), .svc_wr(svc_wr),
    .rst_req(rst_req), .cfg_q(cfg_q), .locked(locked), .cnt(cnt), .win_open(win_open)
);

// File: tb/sim_wdog_top.sv
`timescale 1ns/1ps
module sim_wdog_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_en = 1'b0;
    logic       cfg_wr = 1'b0;
    logic       cfg_bus_clk = 1'b0;
    logic       cfg_window = 1'b0;
    logic [1:0] cfg_tsel = 2'b00;
    logic       svc_wr = 1'b0;
    logic [7:0] svc_data = 8'h00;
    logic       rst_req;

    int total = 0;
    int bad   = 0;
    bit done_flag = 1'b0;

    always #2.5 clk = ~clk;

    wdog_top u0 (
        .clk(clk), .rst(rst), .tick_en(tick_en), .cfg_wr(cfg_wr),
        .cfg_bus_clk(cfg_bus_clk), .cfg_window(cfg_window), .cfg_tsel(cfg_tsel),
        .svc_wr(svc_wr), .svc_data(svc_data), .rst_req(rst_req)
    );

    // Expected period lengths from the requirements.
    function automatic int lp_len(input int sel);
        return (sel == 1) ? 32 : (sel == 2) ? 256 : 1024;
    endfunction
    function automatic int bc_len(input int sel);
        return (sel == 1) ? 8192 : (sel == 2) ? 65536 : 262144;
    endfunction
    function automatic int bc_open(input int sel);
        return bc_len(sel) - bc_len(sel) / 4;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cfg(input bit bus, input bit win, input logic [1:0] sel);
        cfg_wr = 1'b1; cfg_bus_clk = bus; cfg_window = win; cfg_tsel = sel;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic svc(input logic [7:0] d);
        svc_wr = 1'b1; svc_data = d;
        @(negedge clk);
        svc_wr = 1'b0;
    endtask

    task automatic run_to_reset(input int exp, input string req);
        int n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!rst_req && n < exp + 20);
        chk(n == exp, req, n, exp);
        @(negedge clk);
        chk(rst_req == 1'b0, "R9", int'(rst_req), 0);
    endtask

    task automatic tick_run(input int exp, input string req);
        int  n = 0;
        bit  seen = 1'b0;
        while (!seen && n < exp + 20) begin
            tick_en = 1'b1;
            @(negedge clk);
            tick_en = 1'b0;
            n++;
            seen = rst_req;
            for (int g = 0; g < int'($urandom_range(3, 0)); g++) begin
                @(negedge clk);
                if (rst_req && !seen) begin seen = 1'b1; n = -n; end
            end
        end
        chk(n == exp, req, n, exp);
    endtask

    initial begin
        int stray;
        int r;
        void'($urandom(32'd1234));
        do_reset();
        chk(rst_req == 1'b0, "R9 reset state", int'(rst_req), 0);

        // R1: off state, random service bytes and ticks
        stray = 0;
        for (int i = 0; i < 2000; i++) begin
            r = int'($urandom_range(2, 0));
            svc_wr   = $urandom_range(1, 0);
            svc_data = (r == 0) ? 8'h55 : (r == 1) ? 8'hAA : 8'($urandom);
            tick_en  = $urandom_range(1, 0);
            @(negedge clk);
            if (rst_req) stray++;
        end
        svc_wr = 1'b0; tick_en = 1'b0;
        chk(stray == 0, "R1 off no request", stray, 0);

        // Low-power source: window bit ignored (R10), period lengths (R2)
        do_reset();
        cfg(1'b0, 1'b1, 2'b01);
        svc(8'h55);
        chk(rst_req == 1'b0, "R10 early write tick mode", int'(rst_req), 0);
        svc(8'h00);
        chk(rst_req == 1'b0, "R10 second write tick mode", int'(rst_req), 0);
        wait_cyc(50);
        chk(rst_req == 1'b0, "R2 no tick no advance", int'(rst_req), 0);
        tick_run(lp_len(1), "R2 sel01");
        cfg(1'b1, 1'b0, 2'b10);
        tick_run(lp_len(2), "R6 source frozen, R2 sel10");
        cfg(1'b1, 1'b1, 2'b11);
        tick_run(lp_len(3), "R2 sel11");

        // Bus source, normal mode
        do_reset();
        cfg(1'b1, 1'b0, 2'b01);
        run_to_reset(bc_len(1), "R3 sel01");
        r = int'($urandom_range(3000, 50));
        wait_cyc(r - 1);
        svc(8'h55);
        svc(8'hAA);
        chk(rst_req == 1'b0, "R4 service no request", int'(rst_req), 0);
        run_to_reset(bc_len(1), "R4 restart after service");
        wait_cyc(99);
        svc(8'h55);
        svc(8'h12);
        chk(rst_req == 1'b0, "R8 abandon no request", int'(rst_req), 0);
        svc(8'hAA);
        chk(rst_req == 1'b0, "R8 lone AA no request", int'(rst_req), 0);
        run_to_reset(bc_len(1) - 103, "R8 no service happened");
        cfg(1'b1, 1'b0, 2'b10);
        run_to_reset(bc_len(2), "R3 sel10");

        // Bus source, window mode
        do_reset();
        cfg(1'b1, 1'b1, 2'b01);
        wait_cyc(bc_open(1) - 1);
        svc(8'h55);
        chk(rst_req == 1'b1, "R5 write one cycle before window", int'(rst_req), 1);
        wait_cyc(bc_open(1));
        svc(8'h55);
        chk(rst_req == 1'b0, "R7 write at window start", int'(rst_req), 0);
        svc(8'hAA);
        chk(rst_req == 1'b0, "R7 second write in window", int'(rst_req), 0);
        run_to_reset(bc_len(1), "R7 window service restarts");
        cfg(1'b0, 1'b0, 2'b01);
        wait_cyc(99);
        svc(8'hAA);
        chk(rst_req == 1'b1, "R6 window stays enabled", int'(rst_req), 1);
        @(negedge clk);
        chk(rst_req == 1'b0, "R9 single pulse", int'(rst_req), 0);

        done_flag = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done_flag) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule